// File: doc/BRIEF.md
# Zero-Cross Gated Attenuation Controller

This block decides when a new volume setting for one audio output channel becomes the level in force. Software writes a 5-bit attenuation code: code 0 is full level, each step down is 1 dB more attenuation, and code 20 is -20 dB. Any code from 21 up means silence. The block then holds the new code pending. The code in force changes only when the channel's signal passes through zero, so that no step is heard. If no zero crossing comes, the change is made after a chosen number of sample periods. The gain itself is applied downstream, which reads the code the block presents.

A per-sample strobe carries the current signed sample, and the block watches it for zero crossings. A global mute bit and a bit that turns off the zero-cross gating change the behaviour. A status bit shows whether a change is still waiting. If a second write arrives while a change is waiting, the older pending code takes effect at once and the wait starts again for the newer code.

Top module: `attn_zc_gate`

## Requirements
- R1: After reset, and whenever reset is asserted, `attnOut` is 0 and `pendingFlag` is 0.
- R2: `attnOut` carries a code where values 0..20 mean 0 dB down to -20 dB in 1 dB steps, and values 21..31 mean mute. A stored code of 21 or above is passed through unchanged. An active mute bit presents the code 21.
- R3: With gating on (`zcBypass` = 0), a write sets `pendingFlag` to 1 at the clock edge that samples it, and leaves `attnOut` unchanged at that edge.
- R4: A zero crossing is a sample strobe whose sample is exactly zero, or whose sign bit (bit 23) differs from the sign bit of the previous strobed sample. The sign held at reset is 0. On a crossing while `pendingFlag` is 1, the pending code appears on `attnOut` and `pendingFlag` clears at that edge.
- R5: If no crossing occurs, the pending code is applied at the N-th strobe after the request. `toutSel` selects N: 00 gives 256, 01 gives 512, 10 gives 1024 and 11 gives 2048. Until that strobe `pendingFlag` stays 1.
- R6: The timeout count advances only on cycles with `sampleValid` high. Cycles without a strobe neither advance the count nor change `attnOut` or `pendingFlag`.
- R7: A write, or a change of `muteReq`, while `pendingFlag` is 1 puts the previously pending code on `attnOut` at once. The newly requested code becomes pending with `pendingFlag` still 1, and the timeout count restarts.
- R8: With `zcBypass` = 1, a write or mute change is applied at the edge that samples it and `pendingFlag` stays 0. Raising `zcBypass` while a change is pending applies it at the next edge.
- R9: Raising `muteReq` requests code 21, and lowering it requests the stored code again. Both follow the same gating rules as a write. Writes made while muted are stored but keep 21 as the requested code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe per audio sample |
| sampleData | input | 24 | Current sample, two's complement |
| wrEn | input | 1 | Level register write strobe |
| wrData | input | 5 | Attenuation code written |
| toutSel | input | 2 | Timeout length select |
| zcBypass | input | 1 | 1 applies level changes immediately |
| muteReq | input | 1 | Global mute request |
| attnOut | output | 5 | Attenuation code in force |
| pendingFlag | output | 1 | 1 while a level change is waiting |

## Verification
The vector table walks the gating through each of its triggers in turn. It covers a sign change from positive to negative and from negative to positive, an exact-zero sample, and a same-sign sample that must not count as a crossing. Each case shows whether the pending code or the previous code is present after the edge. The table also covers overlapping writes, bypassed writes, and mute rising and falling. These separate the "force old pending through" path from the normal load path. Each timeout length is run with samples of one sign only. The 256 case has idle gaps between strobes. This shows whether the count runs on strobes or on clock cycles, and whether it expires exactly on the N-th strobe rather than one early or late.

// File: rtl/attn_zc_pkg.sv
package attn_zc_pkg;

  // Strobes the control path issues to the level datapath.
  typedef struct packed {
    logic loadPend;   // capture the requested code as pending
    logic applyPend;  // move the pending code to the output
    logic applyNew;   // move the requested code straight to the output
  } ctlStrobes_t;

  localparam int unsigned MUTE_LEVEL = 21;

endpackage

// File: rtl/attn_zc_detect.sv
module attn_zc_detect #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                zcHit
);

  localparam int SIGN_BIT = SAMPLE_W - 1;

  logic prevSign;
  logic isZero;
  logic signFlip;

  assign isZero   = (sampleData == '0);
  assign signFlip = sampleData[SIGN_BIT] ^ prevSign;
  assign zcHit    = sampleValid && (isZero || signFlip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevSign <= 1'b0;
    end else if (sampleValid) begin
      prevSign <= sampleData[SIGN_BIT];
    end
  end

endmodule

// File: rtl/attn_zc_ctrl.sv
module attn_zc_ctrl
  import attn_zc_pkg::*;
#(
  parameter int BASE_TIMEOUT = 256,
  parameter int SEL_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             muteReq,
  input  logic             zcBypass,
  input  logic             sampleValid,
  input  logic             zcHit,
  input  logic [SEL_W-1:0] toutSel,
  output ctlStrobes_t      strb,
  output logic             pendingFlag
);

  localparam int MAX_TIMEOUT = BASE_TIMEOUT << ((1 << SEL_W) - 1);
  localparam int CNT_W       = $clog2(MAX_TIMEOUT);

  logic             muteQ;
  logic             flagQ;
  logic             flagD;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;
  logic [CNT_W-1:0] limitM1;
  logic             request;
  logic             expire;

  assign limitM1 = CNT_W'((BASE_TIMEOUT << toutSel) - 1);
  assign request = wrEn || (muteReq != muteQ);
  assign expire  = sampleValid && (cntQ == limitM1);

  always_comb begin
    strb  = '0;
    flagD = flagQ;
    cntD  = cntQ;
    if (request) begin
      cntD = '0;
      if (zcBypass) begin
        strb.applyNew = 1'b1;
        flagD         = 1'b0;
      end else begin
        strb.loadPend  = 1'b1;
        strb.applyPend = flagQ;
        flagD          = 1'b1;
      end
    end else if (flagQ) begin
      if (zcBypass || zcHit || expire) begin
        strb.applyPend = 1'b1;
        flagD          = 1'b0;
        cntD           = '0;
      end else if (sampleValid) begin
        cntD = cntQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      muteQ <= 1'b0;
      flagQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      muteQ <= muteReq;
      flagQ <= flagD;
      cntQ  <= cntD;
    end
  end

  assign pendingFlag = flagQ;

endmodule

// File: rtl/attn_zc_dpath.sv
module attn_zc_dpath
  import attn_zc_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [LVL_W-1:0] wrData,
  input  logic             muteReq,
  input  ctlStrobes_t      strb,
  output logic [LVL_W-1:0] attnOut
);

  localparam logic [LVL_W-1:0] MUTE_CODE = LVL_W'(MUTE_LEVEL);

  logic [LVL_W-1:0] storedQ;
  logic [LVL_W-1:0] pendQ;
  logic [LVL_W-1:0] activeQ;
  logic [LVL_W-1:0] levelNow;
  logic [LVL_W-1:0] target;

  assign levelNow = wrEn ? wrData : storedQ;
  assign target   = muteReq ? MUTE_CODE : levelNow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      storedQ <= '0;
      pendQ   <= '0;
      activeQ <= '0;
    end else begin
      if (wrEn)          storedQ <= wrData;
      if (strb.loadPend) pendQ   <= target;
      if (strb.applyNew) activeQ <= target;
      else if (strb.applyPend) activeQ <= pendQ;
    end
  end

  assign attnOut = activeQ;

endmodule

// File: rtl/attn_zc_gate.sv
module attn_zc_gate
  import attn_zc_pkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int LVL_W        = 5,
  parameter int SEL_W        = 2,
  parameter int BASE_TIMEOUT = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                wrEn,
  input  logic [LVL_W-1:0]    wrData,
  input  logic [SEL_W-1:0]    toutSel,
  input  logic                zcBypass,
  input  logic                muteReq,
  output logic [LVL_W-1:0]    attnOut,
  output logic                pendingFlag
);

  ctlStrobes_t strb;
  logic        zcHit;

  attn_zc_detect #(.SAMPLE_W(SAMPLE_W)) u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .zcHit       (zcHit)
  );

  attn_zc_ctrl #(.BASE_TIMEOUT(BASE_TIMEOUT), .SEL_W(SEL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrEn        (wrEn),
    .muteReq     (muteReq),
    .zcBypass    (zcBypass),
    .sampleValid (sampleValid),
    .zcHit       (zcHit),
    .toutSel     (toutSel),
    .strb        (strb),
    .pendingFlag (pendingFlag)
  );

  attn_zc_dpath #(.LVL_W(LVL_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .muteReq (muteReq),
    .strb    (strb),
    .attnOut (attnOut)
  );

endmodule

// File: rtl/attn_zc_gate_chk.sv
module attn_zc_gate_chk #(
  parameter int SAMPLE_W = 24,
  parameter int LVL_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] sampleData,
  input logic                wrEn,
  input logic [LVL_W-1:0]    wrData,
  input logic                zcBypass,
  input logic                muteReq,
  input logic [LVL_W-1:0]    attnOut,
  input logic                pendingFlag
);

  logic muteLast;
  always_ff @(posedge clk) begin
    if (!rst_n) muteLast <= 1'b0;
    else        muteLast <= muteReq;
  end

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (attnOut == '0) && !pendingFlag); // R1

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pendingFlag && !zcBypass |=> $stable(attnOut)); // R3

  AST_WRITE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && !zcBypass |=> pendingFlag); // R3

  AST_ZERO_SAMPLE_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    pendingFlag && sampleValid && (sampleData == '0) && !wrEn && (muteReq == muteLast)
    |=> !pendingFlag); // R4

  AST_NO_STROBE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    pendingFlag && !sampleValid && !zcBypass && !wrEn && (muteReq == muteLast)
    |=> pendingFlag && $stable(attnOut)); // R6

  AST_BYPASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    zcBypass |=> !pendingFlag); // R8

  AST_BYPASS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && zcBypass && !muteReq |=> attnOut == $past(wrData)); // R8

endmodule

bind attn_zc_gate attn_zc_gate_chk #(.SAMPLE_W(SAMPLE_W), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sampleValid (sampleValid),
  .sampleData  (sampleData),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .zcBypass    (zcBypass),
  .muteReq     (muteReq),
  .attnOut     (attnOut),
  .pendingFlag (pendingFlag)
);

// File: tb/attn_zc_gate_tb.sv
module attn_zc_gate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] sampleData = '0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrData = '0;
  logic [1:0]  toutSel = '0;
  logic        zcBypass = 1'b0;
  logic        muteReq = 1'b0;
  logic [4:0]  attnOut;
  logic        pendingFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  attn_zc_gate u_dut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleData(sampleData),
    .wrEn(wrEn), .wrData(wrData), .toutSel(toutSel), .zcBypass(zcBypass),
    .muteReq(muteReq), .attnOut(attnOut), .pendingFlag(pendingFlag)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  data;
    logic        byp;
    logic        mute;
    logic        sv;
    logic [23:0] smp;
    logic [4:0]  expAttn;
    logic        expFlag;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd5,  1'b0, 1'b0, 1'b0, 24'd0,          5'd0,  1'b1}, // R3
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'd100,        5'd0,  1'b1}, // R4 same sign
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'hFFFFCE,     5'd5,  1'b0}, // R4 to negative
    '{1'b1, 5'd9,  1'b0, 1'b0, 1'b0, 24'd0,          5'd5,  1'b1}, // R3
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'hFFFFF9,     5'd5,  1'b1}, // R4 stays negative
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'd0,          5'd9,  1'b0}, // R4 exact zero
    '{1'b1, 5'd12, 1'b1, 1'b0, 1'b0, 24'd0,          5'd12, 1'b0}, // R8
    '{1'b1, 5'd3,  1'b0, 1'b0, 1'b0, 24'd0,          5'd12, 1'b1}, // R3
    '{1'b1, 5'd7,  1'b0, 1'b0, 1'b0, 24'd0,          5'd3,  1'b1}, // R7
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'd4,          5'd3,  1'b1}, // R4
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'hFFFFFC,     5'd7,  1'b0}, // R4
    '{1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 24'd0,          5'd7,  1'b1}, // R9 mute on
    '{1'b0, 5'd0,  1'b0, 1'b1, 1'b1, 24'd1,          5'd21, 1'b0}, // R9 R2
    '{1'b1, 5'd2,  1'b0, 1'b1, 1'b0, 24'd0,          5'd21, 1'b1}, // R9 write while muted
    '{1'b0, 5'd0,  1'b0, 1'b1, 1'b1, 24'd2,          5'd21, 1'b1}, // R9
    '{1'b0, 5'd0,  1'b0, 1'b1, 1'b1, 24'hFFFFFE,     5'd21, 1'b0}, // R9
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 24'd0,          5'd21, 1'b1}, // R9 mute off
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'hFFFFFD,     5'd21, 1'b1}, // R4
    '{1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 24'd3,          5'd2,  1'b0}, // R9 restore
    '{1'b1, 5'd25, 1'b1, 1'b0, 1'b0, 24'd0,          5'd25, 1'b0}, // R2 R8
    '{1'b1, 5'd20, 1'b0, 1'b0, 1'b0, 24'd0,          5'd25, 1'b1}, // R3
    '{1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 24'd0,          5'd20, 1'b0}  // R8 late bypass
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [4:0] d, input logic byp,
                       input logic mute, input logic sv, input logic [23:0] smp);
    wrEn = wr; wrData = d; zcBypass = byp; muteReq = mute;
    sampleValid = sv; sampleData = smp;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [4:0] oldAttn;
    logic [4:0] newAttn;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset attn", attnOut, 0);
    chk("R1 reset flag", pendingFlag, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].wr, VECS[v].data, VECS[v].byp, VECS[v].mute, VECS[v].sv, VECS[v].smp);
      chk($sformatf("vector %0d attn (R2 R3 R4 R7 R8 R9)", v), attnOut, VECS[v].expAttn);
      chk($sformatf("vector %0d flag (R3 R4 R7 R8 R9)", v), pendingFlag, VECS[v].expFlag);
    end
    drive(0, 0, 0, 0, 0, 0);

    // R5 timeouts, R6 strobe-only counting (gaps on the shortest setting)
    for (int sel = 0; sel < 4; sel++) begin
      toutSel = 2'(sel);
      oldAttn = attnOut;
      newAttn = 5'(sel + 1);
      n = 256 << sel;
      drive(1, newAttn, 0, 0, 0, 0);
      for (int i = 0; i < n - 1; i++) begin
        drive(0, 0, 0, 0, 1, 24'd10);
        if (sel == 0) drive(0, 0, 0, 0, 0, 24'd10);
      end
      chk($sformatf("R5 R6 sel %0d still waiting flag", sel), pendingFlag, 1);
      chk($sformatf("R5 R6 sel %0d still old attn", sel), attnOut, oldAttn);
      drive(0, 0, 0, 0, 1, 24'd10);
      chk($sformatf("R5 sel %0d applied attn", sel), attnOut, newAttn);
      chk($sformatf("R5 sel %0d flag cleared", sel), pendingFlag, 0);
    end

    // R7 restart of the wait after an overlapping write
    toutSel = 2'd0;
    drive(1, 5'd11, 0, 0, 0, 0);
    for (int i = 0; i < 100; i++) drive(0, 0, 0, 0, 1, 24'd10);
    drive(1, 5'd13, 0, 0, 0, 0);
    chk("R7 forced old pending", attnOut, 11);
    for (int i = 0; i < 255; i++) drive(0, 0, 0, 0, 1, 24'd10);
    chk("R7 restarted count still waiting", pendingFlag, 1);
    drive(0, 0, 0, 0, 1, 24'd10);
    chk("R7 restarted count expires", attnOut, 13);

    // R1 reset while pending
    drive(1, 5'd8, 0, 0, 0, 0);
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0);
    chk("R1 mid-run reset attn", attnOut, 0);
    chk("R1 mid-run reset flag", pendingFlag, 0);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule